// File: doc/BRIEF.md
# Auto-Increment Buffer Pointer Port

This block gives a host byte-wide entry into a paged packet buffer memory. A 16-bit pointer register selects the byte the host reaches through a four-lane data window. One pointer bit picks the page. When it is set, the page is the one at the head of the receive queue. When it is clear, the page is the one held in the packet-number register. Both page numbers arrive as inputs from logic outside the block. The low eleven pointer bits give the byte offset inside a 2 KB page.

A second pointer bit selects how addresses are formed. In auto-increment mode every access uses the pointer offset unchanged and then advances it by one. In lane mode the pointer stays still and the data-window lane is added to the offset. The buffer itself is a synchronous RAM outside the block, driven through a page/offset port. Read data returns to the host one cycle after the access strobe. A host that issues a wider access splits it into byte strobes, lowest address first, so auto-increment advances once per byte.

Top module: `bufwin_port`

## Requirements
- R1: After reset the pointer reads back as 0x0000, `rd_valid` is low and `ram_en` is low while no access is requested.
- R2: A pointer write with `ptr_wr_hi`=0 replaces pointer bits 7:0 only, and with `ptr_wr_hi`=1 replaces bits 15:8 only. Reading with `ptr_rd_hi`=0 returns bits 7:0 unchanged.
- R3: Reading with `ptr_rd_hi`=1 returns pointer bits 15:8 ANDed with 0xF7, so bit 11 always reads 0 even though it is stored.
- R4: During an access, `ram_page` equals `rxq_head` when pointer bit 15 is 1 and equals `pkt_num` when it is 0.
- R5: With pointer bit 14 clear, `ram_ofs` equals (pointer bits 10:0 + `acc_lane`) modulo 2048, and the pointer is left unchanged by the access.
- R6: With pointer bit 14 set, `ram_ofs` equals pointer bits 10:0 and `acc_lane` has no effect. After the access, bits 10:0 advance by one, wrapping from 0x7FF to 0x000, and bits 15:11 keep their value.
- R7: A host write (`acc_write`=1) drives `ram_en`=1, `ram_we`=1 and `ram_wdata`=`acc_wdata` in the strobe cycle. A host read drives `ram_en`=1 and `ram_we`=0.
- R8: One cycle after a read strobe, `rd_valid` is 1 and `rd_data` equals the RAM's read data for the strobed address. In every other cycle, including the one after a write, `rd_valid` is 0 and `rd_data` is 0.
- R9: When a pointer byte write and an auto-increment access fall in the same cycle, the access uses the old pointer. The written byte takes the host value, the other byte keeps its value from before the access, and the increment is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ptr_wr_en | input | 1 | Pointer byte write strobe |
| ptr_wr_hi | input | 1 | Selects the pointer byte to write: 1 = bits 15:8 |
| ptr_wr_data | input | 8 | Pointer byte write value |
| ptr_rd_hi | input | 1 | Selects the pointer byte to read: 1 = bits 15:8 (masked) |
| ptr_rd_data | output | 8 | Pointer byte readback |
| acc_valid | input | 1 | Data-window byte access strobe |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_lane | input | 2 | Data-window lane (0 to 3) |
| acc_wdata | input | 8 | Byte to write |
| rd_valid | output | 1 | Read data valid, one cycle after a read strobe |
| rd_data | output | 8 | Read data |
| rxq_head | input | PAGE_W | Page at the head of the receive queue |
| pkt_num | input | PAGE_W | Page in the packet-number register |
| ram_en | output | 1 | RAM access enable |
| ram_we | output | 1 | RAM write enable |
| ram_page | output | PAGE_W | RAM page address |
| ram_ofs | output | 11 | RAM byte offset within the page |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data, valid one cycle after `ram_en` |

## Verification
The bench builds the block with PAGE_W=3, giving eight pages. With that many pages, randomly drawn head and packet-number pages usually differ, so a wrong page selection shows up as a wrong address. The offset width is fixed at eleven bits by the pointer layout. Loading offsets near 0x7FF therefore reaches the auto-increment wrap and the lane-sum wrap within a few accesses, and random pointer bytes exercise both addressing modes and the stored-but-masked bit 11.

// File: rtl/bufwin_pkg.sv
package bufwin_pkg;
    localparam int PTR_W      = 16;
    localparam int BYTE_W     = 8;
    localparam int OFS_W      = 11;
    localparam int LANE_W     = 2;
    localparam int PAGE_SEL_B = 15;
    localparam int AUTO_INC_B = 14;
    localparam logic [BYTE_W-1:0] HI_RD_MASK = 8'hF7;

    typedef struct packed {
        logic [PTR_W-1:0] ptr;
    } ptr_state_t;

    typedef struct packed {
        logic             valid;
    } rd_state_t;
endpackage

// File: rtl/bufwin_ptr_reg.sv
module bufwin_ptr_reg
    import bufwin_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_hi,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              acc_valid,
    output logic [PTR_W-1:0]  ptr_q
);
    ptr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            // a byte write overrides any increment in the same cycle
            if (wr_hi) begin
                st_d.ptr[PTR_W-1:BYTE_W] = wr_data;
            end else begin
                st_d.ptr[BYTE_W-1:0] = wr_data;
            end
        end else if (acc_valid && st_q.ptr[AUTO_INC_B]) begin
            st_d.ptr[OFS_W-1:0] = st_q.ptr[OFS_W-1:0] + OFS_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ptr_q = st_q.ptr;
endmodule

// File: rtl/bufwin_addr_gen.sv
module bufwin_addr_gen
    import bufwin_pkg::*;
#(
    parameter int PAGE_W = 2
) (
    input  logic              page_sel,
    input  logic              auto_inc,
    input  logic [OFS_W-1:0]  ptr_ofs,
    input  logic [PAGE_W-1:0] rxq_head,
    input  logic [PAGE_W-1:0] pkt_num,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [LANE_W-1:0] acc_lane,
    input  logic [BYTE_W-1:0] acc_wdata,
    output logic              ram_en,
    output logic              ram_we,
    output logic [PAGE_W-1:0] ram_page,
    output logic [OFS_W-1:0]  ram_ofs,
    output logic [BYTE_W-1:0] ram_wdata
);
    localparam int PAD_W = OFS_W - LANE_W;

    logic [OFS_W-1:0] lane_ext;

    always_comb begin
        lane_ext  = {{PAD_W{1'b0}}, acc_lane};
        ram_en    = acc_valid;
        ram_we    = acc_valid && acc_write;
        ram_page  = page_sel ? rxq_head : pkt_num;
        ram_ofs   = auto_inc ? ptr_ofs : (ptr_ofs + lane_ext);
        ram_wdata = acc_wdata;
    end
endmodule

// File: rtl/bufwin_rd_return.sv
module bufwin_rd_return
    import bufwin_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_strobe,
    input  logic [BYTE_W-1:0] ram_rdata,
    output logic              rd_valid,
    output logic [BYTE_W-1:0] rd_data
);
    rd_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.valid = rd_strobe;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_valid = st_q.valid;
    assign rd_data  = st_q.valid ? ram_rdata : '0;
endmodule

// File: rtl/bufwin_port.sv
module bufwin_port
    import bufwin_pkg::*;
#(
    parameter int PAGE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ptr_wr_en,
    input  logic              ptr_wr_hi,
    input  logic [7:0]        ptr_wr_data,
    input  logic              ptr_rd_hi,
    output logic [7:0]        ptr_rd_data,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [1:0]        acc_lane,
    input  logic [7:0]        acc_wdata,
    output logic              rd_valid,
    output logic [7:0]        rd_data,
    input  logic [PAGE_W-1:0] rxq_head,
    input  logic [PAGE_W-1:0] pkt_num,
    output logic              ram_en,
    output logic              ram_we,
    output logic [PAGE_W-1:0] ram_page,
    output logic [10:0]       ram_ofs,
    output logic [7:0]        ram_wdata,
    input  logic [7:0]        ram_rdata
);
    logic [PTR_W-1:0] ptr_q;

    bufwin_ptr_reg u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (ptr_wr_en),
        .wr_hi     (ptr_wr_hi),
        .wr_data   (ptr_wr_data),
        .acc_valid (acc_valid),
        .ptr_q     (ptr_q)
    );

    bufwin_addr_gen #(.PAGE_W(PAGE_W)) u_addr (
        .page_sel  (ptr_q[PAGE_SEL_B]),
        .auto_inc  (ptr_q[AUTO_INC_B]),
        .ptr_ofs   (ptr_q[OFS_W-1:0]),
        .rxq_head  (rxq_head),
        .pkt_num   (pkt_num),
        .acc_valid (acc_valid),
        .acc_write (acc_write),
        .acc_lane  (acc_lane),
        .acc_wdata (acc_wdata),
        .ram_en    (ram_en),
        .ram_we    (ram_we),
        .ram_page  (ram_page),
        .ram_ofs   (ram_ofs),
        .ram_wdata (ram_wdata)
    );

    bufwin_rd_return u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_strobe (acc_valid && !acc_write),
        .ram_rdata (ram_rdata),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data)
    );

    assign ptr_rd_data = ptr_rd_hi ? (ptr_q[PTR_W-1:BYTE_W] & HI_RD_MASK)
                                   : ptr_q[BYTE_W-1:0];
endmodule

// File: rtl/bufwin_port_chk.sv
module bufwin_port_chk
    import bufwin_pkg::*;
#(
    parameter int PAGE_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ptr_wr_en,
    input logic              acc_valid,
    input logic              acc_write,
    input logic              rd_valid,
    input logic [PAGE_W-1:0] rxq_head,
    input logic [PAGE_W-1:0] pkt_num,
    input logic              ram_en,
    input logic              ram_we,
    input logic [PAGE_W-1:0] ram_page,
    input logic [PTR_W-1:0]  ptr_q
);
    assert_page_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ram_en |-> ram_page == (ptr_q[PAGE_SEL_B] ? rxq_head : pkt_num));

    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !ptr_wr_en && !ptr_q[AUTO_INC_B]) |=> $stable(ptr_q));

    assert_inc_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !ptr_wr_en && ptr_q[AUTO_INC_B]) |=>
            ptr_q[OFS_W-1:0] == $past(ptr_q[OFS_W-1:0]) + OFS_W'(1));

    assert_keep_top_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !ptr_wr_en && ptr_q[AUTO_INC_B]) |=>
            ptr_q[PTR_W-1:OFS_W] == $past(ptr_q[PTR_W-1:OFS_W]));

    assert_we_en_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> ram_en);

    assert_rd_lat_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_write) |=> rd_valid);

    assert_no_rd_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_valid && !acc_write) |=> !rd_valid);
endmodule

bind bufwin_port bufwin_port_chk #(.PAGE_W(PAGE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ptr_wr_en (ptr_wr_en),
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .rd_valid  (rd_valid),
    .rxq_head  (rxq_head),
    .pkt_num   (pkt_num),
    .ram_en    (ram_en),
    .ram_we    (ram_we),
    .ram_page  (ram_page),
    .ptr_q     (ptr_q)
);

// File: tb/bufwin_port_bench.sv
`timescale 1ns/1ps
module bufwin_port_bench;
    localparam int PW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ptr_wr_en = 1'b0, ptr_wr_hi = 1'b0;
    logic [7:0]    ptr_wr_data = '0;
    logic          ptr_rd_hi = 1'b0;
    logic [7:0]    ptr_rd_data;
    logic          acc_valid = 1'b0, acc_write = 1'b0;
    logic [1:0]    acc_lane = '0;
    logic [7:0]    acc_wdata = '0;
    logic          rd_valid;
    logic [7:0]    rd_data;
    logic [PW-1:0] rxq_head = '0, pkt_num = '0;
    logic          ram_en, ram_we;
    logic [PW-1:0] ram_page;
    logic [10:0]   ram_ofs;
    logic [7:0]    ram_wdata;
    logic [7:0]    ram_rdata = '0;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    logic [15:0] mptr = '0;

    always #2.5 clk = ~clk;

    bufwin_port #(.PAGE_W(PW)) u_bufwin_port (.*);

    function automatic logic [7:0] pat(logic [PW-1:0] pg, logic [10:0] o);
        return 8'(o) ^ 8'(o >> 8) * 8'h1D ^ 8'(pg) * 8'h35;
    endfunction

    always_ff @(posedge clk)
        if (ram_en && !ram_we) ram_rdata <= pat(ram_page, ram_ofs);

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_ptr(string req);
        ptr_rd_hi = 1'b0; #1;
        chk(req, ptr_rd_data, mptr[7:0]);
        ptr_rd_hi = 1'b1; #1;
        chk(req, ptr_rd_data, mptr[15:8] & 8'hF7);
        ptr_rd_hi = 1'b0;
    endtask

    task automatic ptr_write(bit hi, logic [7:0] d);
        @(negedge clk);
        ptr_wr_en = 1'b1; ptr_wr_hi = hi; ptr_wr_data = d;
        @(negedge clk);
        ptr_wr_en = 1'b0;
        if (hi) mptr[15:8] = d; else mptr[7:0] = d;
    endtask

    // one data-window byte access, optional simultaneous pointer write (R9)
    task automatic access(bit we, logic [1:0] lane, logic [7:0] d,
                          bit pw, bit pw_hi, logic [7:0] pw_d);
        logic [PW-1:0] epg;
        logic [10:0]   eofs;
        epg  = mptr[15] ? rxq_head : pkt_num;
        eofs = mptr[14] ? mptr[10:0] : 11'(mptr[10:0] + 11'(lane));
        @(negedge clk);
        acc_valid = 1'b1; acc_write = we; acc_lane = lane; acc_wdata = d;
        ptr_wr_en = pw; ptr_wr_hi = pw_hi; ptr_wr_data = pw_d;
        #1;
        chk("R4 page", ram_page, epg);
        chk(mptr[14] ? "R6 offset" : "R5 offset", ram_ofs, eofs);
        chk("R7 en/we", {ram_en, ram_we}, {1'b1, we});
        if (we) chk("R7 wdata", ram_wdata, d);
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0; ptr_wr_en = 1'b0;
        #1;
        chk("R8 valid", rd_valid, !we);
        chk("R8 data", rd_data, we ? 8'h00 : pat(epg, eofs));
        if (pw) begin
            if (pw_hi) mptr[15:8] = pw_d; else mptr[7:0] = pw_d;
        end else if (mptr[14]) begin
            mptr[10:0] = mptr[10:0] + 11'd1;
        end
        check_ptr(pw ? "R9 pointer" : (mptr[14] ? "R6 pointer" : "R5 pointer"));
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        #1;
        chk("R1 ram_en", ram_en, 0);
        chk("R1 rd_valid", rd_valid, 0);
        rst_n = 1'b1;
        check_ptr("R1 pointer");

        // R2 independent bytes, R3 masked bit 11
        ptr_write(1'b0, 8'hA5); check_ptr("R2 low byte");
        ptr_write(1'b1, 8'h3F); check_ptr("R3 high mask");
        ptr_write(1'b0, 8'h5A); check_ptr("R2 high kept");

        rxq_head = 3'd5; pkt_num = 3'd2;
        // R5 lane mode with offset wrap: 0x7FE + 3 -> 0x001
        ptr_write(1'b1, 8'h07); ptr_write(1'b0, 8'hFE);
        access(1'b0, 2'd3, 8'h00, 0, 0, 8'h00);
        access(1'b1, 2'd1, 8'hC3, 0, 0, 8'h00);
        // R6 auto-increment wrap with bit 11 and bit 15 kept: 0xC8 top, 0x7FF
        ptr_write(1'b1, 8'hCF); ptr_write(1'b0, 8'hFF);
        access(1'b0, 2'd2, 8'h00, 0, 0, 8'h00);
        access(1'b0, 2'd3, 8'h00, 0, 0, 8'h00);
        access(1'b1, 2'd0, 8'h77, 0, 0, 8'h00);
        // R9 pointer write with auto-increment access
        access(1'b0, 2'd0, 8'h00, 1, 0, 8'h10);
        access(1'b1, 2'd1, 8'h11, 1, 1, 8'h41);

        for (int i = 0; i < 400; i++) begin
            rxq_head = PW'($urandom);
            pkt_num  = PW'($urandom);
            if ($urandom_range(0, 3) == 0)
                ptr_write(1'($urandom), 8'($urandom));
            access(1'($urandom), 2'($urandom), 8'($urandom),
                   $urandom_range(0, 9) == 0, 1'($urandom), 8'($urandom));
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule